// File: doc/BRIEF.md
# Dual-Lane Precise Exception Commit Arbiter

This block sits at the commit point at the end of a two-wide in-order pipeline. Each cycle, up to two instructions finish together, one in lane A and one in lane B. Each lane gives a valid bit, an exception flag, a 4-bit cause and a PC. A single order bit shows which lane holds the older instruction of the pair. This bit is needed because steering can place the older instruction in lane B. One case is a load, which may only use lane B, paired with a following system call, which then lands in lane A.

From these inputs the block works out which lanes commit and whether a trap is raised. When a trap is raised, it also supplies the trap's cause and PC. A faulting older instruction wins the trap, and the instruction after it is killed. A faulting younger instruction still lets the older one commit, and then it takes the trap itself. A flush pulse goes out in the same cycle as the trap. All outputs are registered and appear one cycle after the inputs are sampled.

Top module: `dual_commit_arbiter`

## Requirements
- R1: When both lanes are valid and neither flags an exception, both commit enables are high one cycle later and no trap is raised.
- R2: A lane whose valid bit is low never commits and never becomes the source of a trap.
- R3: When the older instruction is valid and faulting, a trap is raised with its cause and PC. The older instruction does not commit, and the younger one is killed whether or not it faulted.
- R4: When the older instruction is valid and clean and the younger one is valid and faulting, the older commits and the trap carries the younger one's cause and PC.
- R5: The order bit `b_is_older` equal to 0 makes lane A the older, and equal to 1 makes lane B the older. Lane position alone never decides priority.
- R6: `flush` is high in exactly the cycles in which `trap_valid` is high. `trap_cause` and `trap_pc` read zero when no trap is raised.
- R7: Every output is zero during reset, and every output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Lane A holds a completing instruction |
| a_exc | input | 1 | Lane A instruction faulted |
| a_cause | input | CAUSE_W | Lane A fault cause |
| a_pc | input | PC_W | Lane A instruction PC |
| b_valid | input | 1 | Lane B holds a completing instruction |
| b_exc | input | 1 | Lane B instruction faulted |
| b_cause | input | CAUSE_W | Lane B fault cause |
| b_pc | input | PC_W | Lane B instruction PC |
| b_is_older | input | 1 | 1: lane B is older in program order; 0: lane A is older |
| commit_a | output | 1 | Commit enable for lane A |
| commit_b | output | 1 | Commit enable for lane B |
| trap_valid | output | 1 | Trap request |
| trap_cause | output | CAUSE_W | Cause of the trapping instruction |
| trap_pc | output | PC_W | PC of the trapping instruction |
| flush | output | 1 | Pipeline flush, in the same cycle as the trap |

## Verification
The assertions check four behaviours on every cycle against the previous cycle's inputs. An invalid lane never commits. A clean valid pair commits in full. A faulting older instruction blocks all commits and raises a trap. A younger-only fault lets the older lane commit while a trap is raised. Only the bench's scenarios can show that the trap cause and PC come from the right lane under both settings of the order bit, that the outputs are zeroed while idle, and that flush ends once the faults stop. To do this, the bench runs every combination of valid, exception and order bits, with varied causes and PCs.

// File: rtl/dual_commit_arbiter.sv
module dual_commit_arbiter #(
  parameter int PC_W    = 32,
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               a_valid,
  input  logic               a_exc,
  input  logic [CAUSE_W-1:0] a_cause,
  input  logic [PC_W-1:0]    a_pc,
  input  logic               b_valid,
  input  logic               b_exc,
  input  logic [CAUSE_W-1:0] b_cause,
  input  logic [PC_W-1:0]    b_pc,
  input  logic               b_is_older,
  output logic               commit_a,
  output logic               commit_b,
  output logic               trap_valid,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic [PC_W-1:0]    trap_pc,
  output logic               flush
);

  logic a_fault, b_fault, a_blocked, b_blocked, a_traps, b_traps;

  assign a_fault   = a_valid & a_exc;
  assign b_fault   = b_valid & b_exc;
  // a faulting older instruction blocks its younger partner
  assign a_blocked = b_is_older & b_fault;
  assign b_blocked = ~b_is_older & a_fault;
  assign a_traps   = a_fault & ~a_blocked;
  assign b_traps   = b_fault & ~b_blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit_a   <= 1'b0;
      commit_b   <= 1'b0;
      trap_valid <= 1'b0;
      trap_cause <= '0;
      trap_pc    <= '0;
      flush      <= 1'b0;
    end else begin
      commit_a   <= a_valid & ~a_exc & ~a_blocked;
      commit_b   <= b_valid & ~b_exc & ~b_blocked;
      trap_valid <= a_traps | b_traps;
      flush      <= a_traps | b_traps;
      trap_cause <= a_traps ? a_cause : (b_traps ? b_cause : '0);
      trap_pc    <= a_traps ? a_pc    : (b_traps ? b_pc    : '0);
    end
  end

  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  logic old_v, old_x, yng_v, yng_x;
  assign old_v = b_is_older ? b_valid : a_valid;
  assign old_x = b_is_older ? b_exc   : a_exc;
  assign yng_v = b_is_older ? a_valid : b_valid;
  assign yng_x = b_is_older ? a_exc   : b_exc;

  p_idle_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !$past(a_valid) && $past(rst_n) |-> !commit_a);

  p_clean_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(rst_n) && $past(a_valid && b_valid && !a_exc && !b_exc)
      |-> commit_a && commit_b && !trap_valid);

  p_older_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(rst_n) && $past(old_v && old_x)
      |-> trap_valid && !commit_a && !commit_b);

  p_younger_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(rst_n) && $past(old_v && !old_x && yng_v && yng_x)
      |-> trap_valid && (commit_a != commit_b));

endmodule

// File: tb/test_dual_commit_arbiter.sv
module test_dual_commit_arbiter;
  localparam int PC_W = 32;
  localparam int CW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_valid = 0, a_exc = 0, b_valid = 0, b_exc = 0, b_is_older = 0;
  logic [CW-1:0] a_cause = '0, b_cause = '0;
  logic [PC_W-1:0] a_pc = '0, b_pc = '0;
  logic commit_a, commit_b, trap_valid, flush;
  logic [CW-1:0] trap_cause;
  logic [PC_W-1:0] trap_pc;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_commit_arbiter #(.PC_W(PC_W), .CAUSE_W(CW)) i_dual_commit_arbiter (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_exc(a_exc), .a_cause(a_cause), .a_pc(a_pc),
    .b_valid(b_valid), .b_exc(b_exc), .b_cause(b_cause), .b_pc(b_pc),
    .b_is_older(b_is_older),
    .commit_a(commit_a), .commit_b(commit_b), .trap_valid(trap_valid),
    .trap_cause(trap_cause), .trap_pc(trap_pc), .flush(flush));

  logic e_ca, e_cb, e_tv;
  logic [CW-1:0] e_cause;
  logic [PC_W-1:0] e_pc;
  string tag;

  task automatic chk(string req, string what, logic [PC_W-1:0] got, logic [PC_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic compare_all();
    chk(tag, "commit_a", {31'b0, commit_a}, {31'b0, e_ca});
    chk(tag, "commit_b", {31'b0, commit_b}, {31'b0, e_cb});
    chk(tag, "trap_valid", {31'b0, trap_valid}, {31'b0, e_tv});
    chk("R6", "flush", {31'b0, flush}, {31'b0, e_tv});
    chk(tag, "trap_cause", {28'b0, trap_cause}, {28'b0, e_cause});
    chk(tag, "trap_pc", trap_pc, e_pc);
  endtask

  // reference model: behavioural, in program-order terms
  task automatic predict();
    logic ov, ox, yv, yx;
    logic [CW-1:0] oc, yc;
    logic [PC_W-1:0] op, yp;
    logic oc_commit, yc_commit;
    if (b_is_older) begin
      ov = b_valid; ox = b_exc; oc = b_cause; op = b_pc;
      yv = a_valid; yx = a_exc; yc = a_cause; yp = a_pc;
    end else begin
      ov = a_valid; ox = a_exc; oc = a_cause; op = a_pc;
      yv = b_valid; yx = b_exc; yc = b_cause; yp = b_pc;
    end
    oc_commit = 0; yc_commit = 0; e_tv = 0; e_cause = '0; e_pc = '0;
    if (ov && ox) begin
      e_tv = 1; e_cause = oc; e_pc = op; tag = "R3";
    end else begin
      if (ov) oc_commit = 1;
      if (yv && yx) begin
        e_tv = 1; e_cause = yc; e_pc = yp;
        tag = ov ? (b_is_older ? "R5" : "R4") : "R2";
      end else begin
        if (yv) yc_commit = 1;
        tag = (ov && yv) ? "R1" : "R2";
      end
    end
    if (b_is_older) begin e_cb = oc_commit; e_ca = yc_commit; end
    else            begin e_ca = oc_commit; e_cb = yc_commit; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R7";
    e_ca = 0; e_cb = 0; e_tv = 0; e_cause = '0; e_pc = '0;
    compare_all();
    rst_n = 1'b1;
    for (int rep = 0; rep < 4; rep++) begin
      for (int c = 0; c < 32; c++) begin
        a_valid = c[0]; a_exc = c[1]; b_valid = c[2]; b_exc = c[3]; b_is_older = c[4];
        a_cause = 4'($urandom()); b_cause = 4'($urandom());
        a_pc = {$urandom()} & 32'hFFFF_FFFC; b_pc = {$urandom()} & 32'hFFFF_FFFC;
        predict();
        @(negedge clk);
        compare_all();
      end
    end
    // idle: outputs clear, flush ends (R6, R7)
    a_valid = 0; b_valid = 0; a_exc = 1; b_exc = 1;
    predict(); tag = "R7";
    @(negedge clk);
    compare_all();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule